// File: doc/BRIEF.md
# I2C Write Master Controller

This block is an I2C bus master that only writes. Software drives it through a small register port with four addresses. It selects master transmit mode, then asks for a start condition by writing to a command register. It feeds bytes, the slave address with its R/W bit first, into a transmit holding register. It then asks for a stop condition with another command write. The block generates SCL and SDA as open-drain enables: a 1 on an enable pulls the line low.

A holding register sits ahead of the shift register. The next byte can be written while the current one is on the wire, so back-to-back bytes go out with no stretched low phase between them. Four flags pace the software: holding register empty, byte finished, acknowledge value, and stop completed. Software clears them explicitly. The SCL half-period is a fixed number of clock cycles set by a parameter.

Top module: `i2cm_wr_master`

## Requirements
- R1: After reset both line enables are 0 and the busy, mode, empty, byte-done, stop and acknowledge outputs are all 0.
- R2: A write to address 1 with bit 1 = 1 and bit 0 = 0 starts a transfer only when busy reads 0 and both mode bits are 1. Busy then reads 1 and SDA falls while SCL stays released. The same write is ignored when busy is 1 or either mode bit is 0.
- R3: A write to address 1 with bits 1 and 0 both 0 while busy is 1 issues a stop after the last pending byte: SCL is released, then SDA rises while SCL is high. When that completes, busy clears and the stop flag sets. The same write while busy is 0 has no effect on the lines or flags.
- R4: Every SCL high phase inside a transfer lasts exactly HALF_CYC cycles, and every low phase lasts at least HALF_CYC cycles. SDA changes while SCL is high only for a start or a stop, and never partway through a byte.
- R5: Each byte written to address 2 goes out MSB first on eight SCL pulses, in write order. SDA is released for the ninth pulse.
- R6: The acknowledge output takes the SDA level sampled at the end of the ninth SCL high phase: 0 means acknowledged, 1 means not acknowledged.
- R7: The empty flag sets when a start is accepted and whenever the holding register moves into the shifter. It clears on a write to address 2, on a write to address 3 with bit 0 = 1, and when a stop completes.
- R8: The byte-done flag sets after the ninth SCL pulse of each byte. It clears on a write to address 3 with bit 1 = 1.
- R9: The stop flag clears on a write to address 3 with bit 2 = 1.
- R10: A byte written while the previous one is still shifting is sent with the SCL low phase after the acknowledge pulse lasting exactly HALF_CYC cycles. A byte written later is sent after a longer low phase.
- R11: A write to address 0 sets the master mode output from bit 1 and the transmit mode output from bit 0. Writing 0 returns both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 command, 2 data, 3 flag clear) |
| reg_wdata | input | DATA_W | Register write data |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| mode_master | output | 1 | Master mode bit |
| mode_xmit | output | 1 | Transmit mode bit |
| bus_busy | output | 1 | Bus busy, set by start, cleared by stop |
| flag_txe | output | 1 | Holding register empty |
| flag_tdone | output | 1 | Byte including acknowledge pulse finished |
| flag_ack | output | 1 | Last acknowledge value (0 = acknowledged) |
| flag_stop | output | 1 | Stop condition completed |

## Verification
The write path is driven with an address-style byte, a second byte queued while the first shifts, an all-ones byte answered with not-acknowledge, and an all-zeros byte. Together these separate bit order, SDA release on the ninth pulse, acknowledge capture for both values, and the back-to-back path from the waiting path. Each low gap is measured so that a buffered byte and a late byte are told apart. Start and stop commands are also issued in the wrong state (mode clear, bus already busy, bus already free) to show they are gated. Every clock the bench decodes the lines against its own byte queue and phase-length counters.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE, ENG_START, ENG_HOLD, ENG_LOW, ENG_HIGH, ENG_STOP_LO, ENG_STOP_HI
  } eng_state_e;

  localparam logic [1:0] RA_MODE = 2'd0;
  localparam logic [1:0] RA_CMD  = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_CLR  = 2'd3;

  localparam int MODE_MST_BIT = 1;
  localparam int MODE_TX_BIT  = 0;
  localparam int CMD_BUSY_BIT = 1;
  localparam int CMD_SS_BIT   = 0;
  localparam int CLR_TXE_BIT  = 0;
  localparam int CLR_DONE_BIT = 1;
  localparam int CLR_STOP_BIT = 2;
endpackage

// File: rtl/i2cm_prescaler.sv
module i2cm_prescaler #(
  parameter int HALF_CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // Phase counter never passes the half-period limit (R4)
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/i2cm_ctrl_regs.sv
module i2cm_ctrl_regs
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              buf_take,
  input  logic              byte_done,
  input  logic              stop_done,
  output logic              mode_master,
  output logic              mode_xmit,
  output logic              bus_busy,
  output logic              start_go,
  output logic              stop_req,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_data,
  output logic              flag_txe,
  output logic              flag_tdone,
  output logic              flag_stop
);
  logic mode_wr, cmd_wr, data_wr, clr_wr;
  logic start_cmd, stop_cmd, start_ok;

  always_comb begin
    mode_wr   = reg_we && (reg_addr == RA_MODE);
    cmd_wr    = reg_we && (reg_addr == RA_CMD);
    data_wr   = reg_we && (reg_addr == RA_DATA);
    clr_wr    = reg_we && (reg_addr == RA_CLR);
    start_cmd = cmd_wr && reg_wdata[CMD_BUSY_BIT] && !reg_wdata[CMD_SS_BIT];
    stop_cmd  = cmd_wr && !reg_wdata[CMD_BUSY_BIT] && !reg_wdata[CMD_SS_BIT];
    start_ok  = start_cmd && !bus_busy && mode_master && mode_xmit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_master <= 1'b0;
      mode_xmit   <= 1'b0;
      bus_busy    <= 1'b0;
      start_go    <= 1'b0;
      stop_req    <= 1'b0;
      buf_full    <= 1'b0;
      buf_data    <= '0;
      flag_txe    <= 1'b0;
      flag_tdone  <= 1'b0;
      flag_stop   <= 1'b0;
    end else begin
      start_go <= start_ok;

      if (mode_wr) begin
        mode_master <= reg_wdata[MODE_MST_BIT];
        mode_xmit   <= reg_wdata[MODE_TX_BIT];
      end

      if (start_ok)       bus_busy <= 1'b1;
      else if (stop_done) bus_busy <= 1'b0;

      if (stop_done)                 stop_req <= 1'b0;
      else if (stop_cmd && bus_busy) stop_req <= 1'b1;

      if (data_wr) begin
        buf_data <= reg_wdata;
        buf_full <= 1'b1;
      end else if (buf_take) begin
        buf_full <= 1'b0;
      end

      if (data_wr || stop_done)                flag_txe <= 1'b0;
      else if (buf_take || start_ok)           flag_txe <= 1'b1;
      else if (clr_wr && reg_wdata[CLR_TXE_BIT]) flag_txe <= 1'b0;

      if (byte_done)                              flag_tdone <= 1'b1;
      else if (clr_wr && reg_wdata[CLR_DONE_BIT]) flag_tdone <= 1'b0;

      if (stop_done)                              flag_stop <= 1'b1;
      else if (clr_wr && reg_wdata[CLR_STOP_BIT]) flag_stop <= 1'b0;
    end
  end

  assert_busy_from_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> $past(cmd_wr) && start_go);

  assert_txe_clear_on_load_R7: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !flag_txe);

  assert_stop_flag_source_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_stop) |-> $past(stop_done));

  assert_no_stop_when_free_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_busy |-> !stop_req);
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_go,
  input  logic              stop_req,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              tick,
  input  logic              sda_in,
  output logic              run,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              buf_take,
  output logic              byte_done,
  output logic              stop_done,
  output logic              ack_val
);
  localparam int BC_W = $clog2(DATA_W + 1);
  localparam logic [BC_W-1:0] ACK_IDX  = BC_W'(DATA_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  eng_state_e        state;
  logic [DATA_W-2:0] rest;
  logic [BC_W-1:0]   bitn;

  always_comb begin
    run = (state == ENG_START) || (state == ENG_LOW) || (state == ENG_HIGH) ||
          (state == ENG_STOP_LO) || (state == ENG_STOP_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      rest      <= '0;
      bitn      <= '0;
      buf_take  <= 1'b0;
      byte_done <= 1'b0;
      stop_done <= 1'b0;
      ack_val   <= 1'b0;
    end else begin
      buf_take  <= 1'b0;
      byte_done <= 1'b0;
      stop_done <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (start_go) begin
            sda_oe <= 1'b1;
            state  <= ENG_START;
          end
        end
        ENG_START: begin
          if (tick) begin
            scl_oe <= 1'b1;
            state  <= ENG_HOLD;
          end
        end
        ENG_HOLD: begin
          if (buf_full) begin
            rest     <= buf_data[DATA_W-2:0];
            bitn     <= '0;
            buf_take <= 1'b1;
            sda_oe   <= ~buf_data[DATA_W-1];
            state    <= ENG_LOW;
          end else if (stop_req) begin
            sda_oe <= 1'b1;
            state  <= ENG_STOP_LO;
          end
        end
        ENG_LOW: begin
          if (tick) begin
            scl_oe <= 1'b0;
            state  <= ENG_HIGH;
          end
        end
        ENG_HIGH: begin
          if (tick) begin
            scl_oe <= 1'b1;
            if (bitn == ACK_IDX) begin
              ack_val   <= sda_in;
              byte_done <= 1'b1;
              if (buf_full) begin
                rest     <= buf_data[DATA_W-2:0];
                bitn     <= '0;
                buf_take <= 1'b1;
                sda_oe   <= ~buf_data[DATA_W-1];
                state    <= ENG_LOW;
              end else begin
                state <= ENG_HOLD;
              end
            end else begin
              bitn   <= bitn + 1'b1;
              rest   <= {rest[DATA_W-3:0], 1'b0};
              sda_oe <= (bitn == LAST_BIT) ? 1'b0 : ~rest[DATA_W-2];
              state  <= ENG_LOW;
            end
          end
        end
        ENG_STOP_LO: begin
          if (tick) begin
            scl_oe <= 1'b0;
            state  <= ENG_STOP_HI;
          end
        end
        ENG_STOP_HI: begin
          if (tick) begin
            sda_oe    <= 1'b0;
            stop_done <= 1'b1;
            state     <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assert_sda_steady_high_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_HIGH && $past(state) == ENG_HIGH) |-> $stable(sda_oe));

  assert_done_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (state == ENG_HOLD || state == ENG_LOW));

  assert_take_needs_data_R10: assert property (@(posedge clk) disable iff (rst)
    buf_take |-> $past(buf_full));
endmodule

// File: rtl/i2cm_wr_master.sv
module i2cm_wr_master #(
  parameter int HALF_CYC = 250,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              mode_master,
  output logic              mode_xmit,
  output logic              bus_busy,
  output logic              flag_txe,
  output logic              flag_tdone,
  output logic              flag_ack,
  output logic              flag_stop
);
  logic              start_go, stop_req, buf_full, buf_take;
  logic              byte_done, stop_done, run, tick;
  logic [DATA_W-1:0] buf_data;

  i2cm_ctrl_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .buf_take(buf_take), .byte_done(byte_done), .stop_done(stop_done),
    .mode_master(mode_master), .mode_xmit(mode_xmit), .bus_busy(bus_busy),
    .start_go(start_go), .stop_req(stop_req),
    .buf_full(buf_full), .buf_data(buf_data),
    .flag_txe(flag_txe), .flag_tdone(flag_tdone), .flag_stop(flag_stop)
  );

  i2cm_prescaler #(.HALF_CYC(HALF_CYC)) presc_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  i2cm_bit_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst(rst),
    .start_go(start_go), .stop_req(stop_req),
    .buf_full(buf_full), .buf_data(buf_data),
    .tick(tick), .sda_in(sda_in),
    .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .buf_take(buf_take), .byte_done(byte_done), .stop_done(stop_done),
    .ack_val(flag_ack)
  );

  assert_lines_free_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!bus_busy && $past(!bus_busy) && !start_go) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2cm_wr_master_tb.sv
module i2cm_wr_master_tb_top;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       scl_oe, sda_oe, mode_master, mode_xmit, bus_busy;
  logic       flag_txe, flag_tdone, flag_ack, flag_stop;
  logic       pull = 1'b0;
  logic       ack_en = 1'b1;
  wire        scl_line = ~scl_oe;
  wire        sda_line = ~(sda_oe | pull);

  always #2 clk = ~clk;

  i2cm_wr_master #(.HALF_CYC(HALF), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .mode_master(mode_master),
    .mode_xmit(mode_xmit), .bus_busy(bus_busy), .flag_txe(flag_txe),
    .flag_tdone(flag_tdone), .flag_ack(flag_ack), .flag_stop(flag_stop)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      chk(0, "watchdog", "run length", cyc, 60000);
      finish_up();
    end
  end

  // Behavioural slave: pulls SDA during the ninth pulse when ack_en is set
  int   s_rises = 0;
  logic s_pscl = 1'b1, s_psda = 1'b1;
  always @(posedge clk) begin
    if (rst) begin
      pull <= 1'b0; s_rises <= 0; s_pscl <= 1'b1; s_psda <= 1'b1;
    end else begin
      s_pscl <= scl_line;
      s_psda <= sda_line;
      if (s_pscl && scl_line && s_psda && !sda_line) s_rises <= 0;
      else if (!s_pscl && scl_line) s_rises <= s_rises + 1;
      else if (s_pscl && !scl_line) begin
        if (s_rises == 8) pull <= ack_en;
        else if (s_rises == 9) begin pull <= 1'b0; s_rises <= 0; end
      end
    end
  end

  // Reference model of the bus: expected bytes, phase lengths, conditions
  logic [7:0] exp_q[$];
  int   starts_seen = 0, stops_seen = 0, bytes_seen = 0;
  int   hi_run = 0, lo_run = 0, bitpos = 0, pend_gap = 0;
  int   gap_of[16];
  bit   rise_seen = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] shb = 8'd0;
  always @(negedge clk) begin
    if (!rst) begin
      if (p_scl && scl_line && p_sda && !sda_line) begin
        starts_seen++;
        chk(bitpos == 0, "R4", "start inside byte, bit", bitpos, 0);
        rise_seen = 0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        stops_seen++;
        chk(bitpos == 0, "R4", "stop inside byte, bit", bitpos, 0);
      end
      if (!p_scl && scl_line) begin
        chk(lo_run >= HALF, "R4", "SCL low length", lo_run, HALF);
        if (bitpos == 0) pend_gap = lo_run;
        hi_run = 1;
        rise_seen = 1;
      end else if (p_scl && !scl_line) begin
        if (rise_seen) begin
          chk(hi_run == HALF, "R4", "SCL high length", hi_run, HALF);
          if (bitpos == 0 && bytes_seen < 16) gap_of[bytes_seen] = pend_gap;
          if (bitpos < 8) begin
            shb = {shb[6:0], p_sda};
            bitpos++;
          end else begin
            if (exp_q.size() == 0) chk(0, "R5", "unexpected byte", shb, -1);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(shb == e, "R5", "byte on bus", shb, e);
            end
            bytes_seen++;
            bitpos = 0;
          end
        end
        lo_run = 1;
      end else if (scl_line) hi_run++;
      else lo_run++;
      p_scl = scl_line;
      p_sda = sda_line;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_flag(input int which, input string req);
    int n;
    logic v;
    n = 0;
    while (1) begin
      @(negedge clk);
      v = (which == 0) ? flag_txe : (which == 1) ? flag_tdone : flag_stop;
      if (v) break;
      n++;
      if (n > 3000) begin
        chk(0, req, "flag wait timeout", 0, 1);
        break;
      end
    end
  endtask

  task automatic send(input logic [7:0] d);
    exp_q.push_back(d);
    wr(2'd2, d);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1", "line enables", {scl_oe, sda_oe}, 0);
    chk(!bus_busy && !mode_master && !mode_xmit, "R1", "busy/mode",
        {bus_busy, mode_master, mode_xmit}, 0);
    chk(!flag_txe && !flag_tdone && !flag_stop && !flag_ack, "R1", "flags",
        {flag_txe, flag_tdone, flag_stop, flag_ack}, 0);

    // R2 start refused with mode bits clear
    wr(2'd1, 8'h02);
    repeat (20) @(negedge clk);
    chk(!bus_busy, "R2", "busy without mode", bus_busy, 0);
    chk(starts_seen == 0, "R2", "starts without mode", starts_seen, 0);

    // R11 mode register
    wr(2'd0, 8'h03);
    chk(mode_master && mode_xmit, "R11", "mode bits", {mode_master, mode_xmit}, 3);

    // R2 start accepted, R7 empty set on start
    wr(2'd1, 8'h02);
    chk(bus_busy, "R2", "busy after start", bus_busy, 1);
    chk(flag_txe, "R7", "empty after start", flag_txe, 1);
    send(8'hA6);
    chk(!flag_txe, "R7", "empty after data write", flag_txe, 0);
    wait_flag(0, "R7");
    chk(flag_txe, "R7", "empty after shifter load", flag_txe, 1);
    chk(starts_seen == 1, "R2", "start condition seen", starts_seen, 1);

    // R10 second byte queued while the first shifts
    send(8'h3C);
    wait_flag(1, "R8");
    chk(flag_tdone, "R8", "byte done set", flag_tdone, 1);
    chk(flag_ack == 1'b0, "R6", "ack from slave", flag_ack, 0);
    wr(2'd3, 8'h02);
    chk(!flag_tdone, "R8", "byte done cleared", flag_tdone, 0);
    wait_flag(1, "R8");
    chk(flag_ack == 1'b0, "R6", "ack second byte", flag_ack, 0);
    wr(2'd3, 8'h02);

    // R6 not-acknowledge on an all-ones byte sent after a wait
    ack_en = 1'b0;
    send(8'hFF);
    wait_flag(1, "R8");
    chk(flag_ack == 1'b1, "R6", "nack captured", flag_ack, 1);
    chk(gap_of[1] == HALF, "R10", "buffered byte gap", gap_of[1], HALF);
    chk(gap_of[2] > HALF, "R10", "late byte gap", gap_of[2], HALF + 1);

    // R7 software clear of empty flag
    chk(flag_txe, "R7", "empty before clear", flag_txe, 1);
    wr(2'd3, 8'h01);
    chk(!flag_txe, "R7", "empty after clear", flag_txe, 0);

    // R3 stop
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h00);
    wait_flag(2, "R3");
    chk(!bus_busy, "R3", "busy after stop", bus_busy, 0);
    chk(!scl_oe && !sda_oe, "R3", "lines after stop", {scl_oe, sda_oe}, 0);
    chk(stops_seen == 1, "R3", "stop condition seen", stops_seen, 1);
    chk(!flag_txe, "R7", "empty after stop", flag_txe, 0);
    chk(exp_q.size() == 0, "R5", "bytes left unsent", exp_q.size(), 0);

    // R9 stop flag clear, R3 stop while free is ignored
    wr(2'd3, 8'h04);
    chk(!flag_stop, "R9", "stop flag cleared", flag_stop, 0);
    wr(2'd1, 8'h00);
    repeat (40) @(negedge clk);
    chk(!flag_stop, "R3", "stop flag after idle stop", flag_stop, 0);
    chk(stops_seen == 1 && !sda_oe && !scl_oe, "R3", "stops after idle stop",
        stops_seen, 1);

    // R11 mode cleared, R2 start refused again
    wr(2'd0, 8'h00);
    chk(!mode_master && !mode_xmit, "R11", "mode cleared", {mode_master, mode_xmit}, 0);
    wr(2'd1, 8'h02);
    repeat (20) @(negedge clk);
    chk(!bus_busy && starts_seen == 1, "R2", "start with mode cleared", starts_seen, 1);

    // R2 second start while busy is ignored; all-zeros byte
    wr(2'd0, 8'h03);
    ack_en = 1'b1;
    wr(2'd1, 8'h02);
    send(8'h00);
    wr(2'd1, 8'h02);
    wait_flag(1, "R8");
    chk(starts_seen == 2, "R2", "start while busy", starts_seen, 2);
    chk(flag_ack == 1'b0, "R6", "ack on zero byte", flag_ack, 0);
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h00);
    wait_flag(2, "R3");
    chk(stops_seen == 2, "R3", "second stop", stops_seen, 2);
    chk(bytes_seen == 4, "R5", "bytes decoded", bytes_seen, 4);
    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule